// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block is the fetch side of a transmit path. Software lays out a ring of two-word descriptors in memory. Each descriptor holds a buffer address and a control word. After a start command the block walks the ring. It fetches each descriptor over a simple word read port, then reads the buffer that the descriptor points to and presents its bytes as an outbound stream with valid/ready flow control. It stops when it reaches a descriptor that software still marks as used.

A frame may span several descriptors. The control word of the frame's first descriptor carries the request to suppress the CRC, and this request follows the stream as a sideband flag. When the last byte of a frame has been accepted, the block writes the first descriptor's control word back with the used flag set. Into the same word it records any underrun or retry-limit indication seen on the sideband inputs, and whether the ring ran dry in the middle of the frame. A halt request takes effect only at a frame boundary. A start issued after a halt begins again at the ring base; a start issued after a plain stop continues at the descriptor where processing stopped.

The reset input is expected to be an active-low asynchronous reset whose release has already been synchronised to `clk`.

Top module: `txr_desc_reader`

## Requirements
- R1: After reset `busy_o`, `tx_valid_o`, `mem_rd_o` and `mem_wr_o` are all low.
- R2: A descriptor at byte address P has its buffer byte address in the word at P and its control word at P+4. Control bits 10:0 give the buffer's byte count. The buffer's bytes are streamed in ascending address order from any start alignment. Byte lane k of a memory word holds address offset k (little-endian).
- R3: Control bit 15 marks the last buffer of a frame. `tx_last_o` is high only on the final byte of that buffer. Buffers of one frame are streamed back to back with no marker between them.
- R4: `tx_nocrc_o` equals control bit 16 of the frame's first descriptor on every beat of that frame.
- R5: A descriptor whose control bit 31 (used) is set at a frame boundary ends processing and `busy_o` falls. A later start without an intervening halt reads that same descriptor again.
- R6: Once the frame's last byte is accepted, the first descriptor's control word is rewritten at P+4. Bit 31 is set, bits 29:27 hold the error record, and all other bits are unchanged. No other descriptor of the frame is written.
- R7: After a descriptor with control bit 30 (wrap) set, the next descriptor is read at the ring base. Otherwise it is read at P+8.
- R8: A used descriptor met inside a frame produces one extra beat with `tx_abort_o` and `tx_last_o` high and data zero. Bit 27 is then set in the write-back, and processing stops.
- R9: A pulse on `underrun_i` or `retry_i` while busy since the previous write-back sets bit 28 or bit 29 respectively in the next write-back. Those bits are clear in later frames' write-backs.
- R10: A halt while busy lets the current frame finish with `busy_o` held high. No further descriptor is fetched, and the next start begins at the ring base.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the data, last and abort outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, synchronously released |
| start_i | input | 1 | Start pulse, honoured when idle |
| halt_i | input | 1 | Halt request, honoured while busy |
| ring_base_i | input | AW | Byte address of the first ring descriptor |
| busy_o | output | 1 | High from start until processing ends |
| mem_rd_o | output | 1 | One-cycle word read request |
| mem_raddr_o | output | AW | Word-aligned read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| mem_wr_o | output | 1 | One-cycle word write request |
| mem_waddr_o | output | AW | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| tx_valid_o | output | 1 | Stream beat valid |
| tx_ready_i | input | 1 | Stream beat accepted |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final beat of a frame |
| tx_abort_o | output | 1 | Frame abandoned, beat carries no data |
| tx_nocrc_o | output | 1 | Downstream should not append a CRC |
| underrun_i | input | 1 | Underrun indication from downstream |
| retry_i | input | 1 | Retry-limit indication from downstream |

## Verification
The bench targets buffers that start mid-word and frames split across descriptors. A design that mis-slices lanes would repeat or skip bytes there, and one that writes back the wrong descriptor would mark the second descriptor used instead of the first. It places a wrap flag ahead of a ready descriptor and expects a jump to the base; a design that ignored wrap would stream that extra frame. Exhaustion in mid-frame must yield an abort beat and bit 27. A halt must not cut a frame short, must not let the next frame start, and must make the following start rewind to the base; a design that kept its pointer would stream the wrong buffer. Sideband errors under backpressure must land on their own frame only, so a design that never cleared its error record would mark the following frame too.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned CNT_W     = 11;
  localparam int unsigned EOF_BIT   = 15;
  localparam int unsigned NOCRC_BIT = 16;
  localparam int unsigned EXH_BIT   = 27;
  localparam int unsigned UNDR_BIT  = 28;
  localparam int unsigned RTRY_BIT  = 29;
  localparam int unsigned WRAP_BIT  = 30;
  localparam int unsigned USED_BIT  = 31;
  localparam int unsigned DESC_STEP = 8;
  localparam int unsigned CTRL_OFS  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WT_ADDR,
    ST_RD_CTRL,
    ST_WT_CTRL,
    ST_EVAL,
    ST_RD_BUF,
    ST_WT_BUF,
    ST_BYTE,
    ST_ABORT,
    ST_WBACK,
    ST_NEXT
  } rd_state_t;

endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  import txr_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(DESC_STEP);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = load_i | adv_i;
    ptr_d  = ptr_q;
    if (load_i) begin
      ptr_d = base_i;
    end else if (adv_i) begin
      ptr_d = wrap_i ? base_i : (ptr_q + STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && wrap_i) |=> (ptr_o == $past(base_i))); // R7
  AST_STEP_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wrap_i && !load_i) |=> (ptr_o == $past(ptr_o) + STEP)); // R7

endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0]         word_i,
  input  logic [$clog2(WORD_W/8)-1:0] sel_i,
  output logic [7:0]                byte_o
);
  localparam int unsigned LANES = WORD_W / 8;

  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign byte_o = lanes[sel_i];

endmodule

// File: rtl/txr_wb_word.sv
module txr_wb_word (
  input  logic [31:0] ctrl_i,
  input  logic        undr_i,
  input  logic        rtry_i,
  input  logic        exh_i,
  output logic [31:0] wb_o
);
  import txr_pkg::*;

  always_comb begin
    wb_o           = ctrl_i;
    wb_o[USED_BIT] = 1'b1;
    wb_o[EXH_BIT]  = exh_i;
    wb_o[UNDR_BIT] = undr_i;
    wb_o[RTRY_BIT] = rtry_i;
  end

endmodule

// File: rtl/txr_desc_reader.sv
module txr_desc_reader #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic [AW-1:0] ring_base_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_raddr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          tx_abort_o,
  output logic          tx_nocrc_o,
  input  logic          underrun_i,
  input  logic          retry_i
);
  import txr_pkg::*;

  localparam int unsigned   OFF_W   = 2;
  localparam logic [AW-1:0] CTRL_AD = AW'(CTRL_OFS);
  localparam logic [CNT_W-1:0] REM_ONE = CNT_W'(1);

  rd_state_t         state_q, state_d;
  logic [AW-1:0]     buf_addr_q, buf_addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [31:0]       word_q, word_d;
  logic              last_q, last_d;
  logic              wrap_q, wrap_d;
  logic [AW-1:0]     first_ptr_q, first_ptr_d;
  logic [31:0]       first_ctrl_q, first_ctrl_d;
  logic              in_frame_q, in_frame_d;
  logic              halt_q, halt_d;
  logic              rewind_q, rewind_d;
  logic              undr_q, undr_d;
  logic              rtry_q, rtry_d;
  logic              exh_q, exh_d;

  logic [AW-1:0]     ptr;
  logic              ptr_load, ptr_adv;
  logic [7:0]        lane_byte;
  logic [31:0]       wb_word;
  logic              busy;

  assign busy = (state_q != ST_IDLE);

  txr_ring_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .base_i (ring_base_i),
    .load_i (ptr_load),
    .adv_i  (ptr_adv),
    .wrap_i (wrap_q),
    .ptr_o  (ptr)
  );

  txr_byte_lane #(.WORD_W(32)) u_lane (
    .word_i (word_q),
    .sel_i  (buf_addr_q[OFF_W-1:0]),
    .byte_o (lane_byte)
  );

  txr_wb_word u_wb (
    .ctrl_i (first_ctrl_q),
    .undr_i (undr_q),
    .rtry_i (rtry_q),
    .exh_i  (exh_q),
    .wb_o   (wb_word)
  );

  // Next-state logic
  always_comb begin
    state_d      = state_q;
    buf_addr_d   = buf_addr_q;
    remain_d     = remain_q;
    word_d       = word_q;
    last_d       = last_q;
    wrap_d       = wrap_q;
    first_ptr_d  = first_ptr_q;
    first_ctrl_d = first_ctrl_q;
    in_frame_d   = in_frame_q;
    rewind_d     = rewind_q;
    exh_d        = exh_q;
    halt_d       = halt_q | (busy & halt_i);
    undr_d       = undr_q | (busy & underrun_i);
    rtry_d       = rtry_q | (busy & retry_i);
    mem_rd_o     = 1'b0;
    mem_raddr_o  = '0;
    mem_wr_o     = 1'b0;
    tx_valid_o   = 1'b0;
    tx_abort_o   = 1'b0;
    ptr_load     = 1'b0;
    ptr_adv      = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        halt_d = 1'b0;
        if (start_i) begin
          ptr_load = rewind_q;
          rewind_d = 1'b0;
          state_d  = ST_RD_ADDR;
        end
      end
      ST_RD_ADDR: begin
        mem_rd_o    = 1'b1;
        mem_raddr_o = ptr;
        state_d     = ST_WT_ADDR;
      end
      ST_WT_ADDR: begin
        if (mem_rvalid_i) begin
          buf_addr_d = mem_rdata_i[AW-1:0];
          state_d    = ST_RD_CTRL;
        end
      end
      ST_RD_CTRL: begin
        mem_rd_o    = 1'b1;
        mem_raddr_o = ptr + CTRL_AD;
        state_d     = ST_WT_CTRL;
      end
      ST_WT_CTRL: begin
        if (mem_rvalid_i) begin
          word_d  = mem_rdata_i;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (word_q[USED_BIT]) begin
          if (in_frame_q) begin
            exh_d   = 1'b1;
            state_d = ST_ABORT;
          end else begin
            rewind_d = rewind_q | halt_q;
            halt_d   = 1'b0;
            state_d  = ST_IDLE;
          end
        end else if (!in_frame_q && halt_q) begin
          rewind_d = 1'b1;
          halt_d   = 1'b0;
          state_d  = ST_IDLE;
        end else begin
          if (!in_frame_q) begin
            first_ptr_d  = ptr;
            first_ctrl_d = word_q;
            in_frame_d   = 1'b1;
          end
          remain_d = word_q[CNT_W-1:0];
          last_d   = word_q[EOF_BIT];
          wrap_d   = word_q[WRAP_BIT];
          if (word_q[CNT_W-1:0] == '0) begin
            state_d = word_q[EOF_BIT] ? ST_WBACK : ST_NEXT;
          end else begin
            state_d = ST_RD_BUF;
          end
        end
      end
      ST_RD_BUF: begin
        mem_rd_o    = 1'b1;
        mem_raddr_o = {buf_addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
        state_d     = ST_WT_BUF;
      end
      ST_WT_BUF: begin
        if (mem_rvalid_i) begin
          word_d  = mem_rdata_i;
          state_d = ST_BYTE;
        end
      end
      ST_BYTE: begin
        tx_valid_o = 1'b1;
        if (tx_ready_i) begin
          buf_addr_d = buf_addr_q + AW'(1);
          remain_d   = remain_q - REM_ONE;
          if (remain_q == REM_ONE) begin
            state_d = last_q ? ST_WBACK : ST_NEXT;
          end else if (buf_addr_q[OFF_W-1:0] == {OFF_W{1'b1}}) begin
            state_d = ST_RD_BUF;
          end
        end
      end
      ST_ABORT: begin
        tx_valid_o = 1'b1;
        tx_abort_o = 1'b1;
        if (tx_ready_i) begin
          state_d = ST_WBACK;
        end
      end
      ST_WBACK: begin
        mem_wr_o   = 1'b1;
        in_frame_d = 1'b0;
        undr_d     = 1'b0;
        rtry_d     = 1'b0;
        exh_d      = 1'b0;
        if (exh_q) begin
          rewind_d = rewind_q | halt_q;
          halt_d   = 1'b0;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        ptr_adv = 1'b1;
        if (!in_frame_q && halt_q) begin
          rewind_d = 1'b1;
          halt_d   = 1'b0;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_RD_ADDR;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      buf_addr_q   <= '0;
      remain_q     <= '0;
      word_q       <= '0;
      last_q       <= 1'b0;
      wrap_q       <= 1'b0;
      first_ptr_q  <= '0;
      first_ctrl_q <= '0;
      in_frame_q   <= 1'b0;
      halt_q       <= 1'b0;
      rewind_q     <= 1'b1;
      undr_q       <= 1'b0;
      rtry_q       <= 1'b0;
      exh_q        <= 1'b0;
    end else begin
      state_q      <= state_d;
      buf_addr_q   <= buf_addr_d;
      remain_q     <= remain_d;
      word_q       <= word_d;
      last_q       <= last_d;
      wrap_q       <= wrap_d;
      first_ptr_q  <= first_ptr_d;
      first_ctrl_q <= first_ctrl_d;
      in_frame_q   <= in_frame_d;
      halt_q       <= halt_d;
      rewind_q     <= rewind_d;
      undr_q       <= undr_d;
      rtry_q       <= rtry_d;
      exh_q        <= exh_d;
    end
  end

  assign busy_o      = busy;
  assign mem_waddr_o = first_ptr_q + CTRL_AD;
  assign mem_wdata_o = wb_word;
  assign tx_data_o   = (state_q == ST_BYTE) ? lane_byte : 8'h00;
  assign tx_last_o   = ((state_q == ST_BYTE) && last_q && (remain_q == REM_ONE))
                     || (state_q == ST_ABORT);
  assign tx_nocrc_o  = tx_valid_o & first_ctrl_q[NOCRC_BIT];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !mem_wr_o && !tx_valid_o)); // R1
  AST_LAST_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_o |-> tx_valid_o); // R3
  AST_ABORT_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_o |-> (tx_last_o && (tx_data_o == 8'h00))); // R8
  AST_WB_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> mem_wdata_o[USED_BIT]); // R6
  AST_ABORT_FLAGS_EXH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && $past(tx_abort_o && tx_ready_i)) |-> mem_wdata_o[EXH_BIT]); // R8
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)
      && $stable(tx_last_o) && $stable(tx_abort_o))); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R6

endmodule

// File: tb/txr_desc_reader_test.sv
module txr_desc_reader_test;

  localparam int unsigned AW = 32;
  localparam logic [31:0] F_EOF   = 32'h0000_8000;
  localparam logic [31:0] F_NOCRC = 32'h0001_0000;
  localparam logic [31:0] F_EXH   = 32'h0800_0000;
  localparam logic [31:0] F_UNDR  = 32'h1000_0000;
  localparam logic [31:0] F_RTRY  = 32'h2000_0000;
  localparam logic [31:0] F_WRAP  = 32'h4000_0000;
  localparam logic [31:0] F_USED  = 32'h8000_0000;

  logic          clk;
  logic          rst_n;
  logic          start, halt;
  logic [AW-1:0] ring_base;
  logic          busy;
  logic          mem_rd, mem_wr, mem_rvalid;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [31:0]   mem_rdata, mem_wdata;
  logic          tx_valid, tx_ready, tx_last, tx_abort, tx_nocrc;
  logic [7:0]    tx_data;
  logic          underrun, retry;

  logic [31:0] mem [64];
  logic [7:0]  cap_data  [64];
  logic        cap_last  [64];
  logic        cap_abort [64];
  logic        cap_nocrc [64];
  int          cap_n;
  logic        bp_mode;
  int          rdy_cnt;
  int          checks, errors;
  logic        done;

  txr_desc_reader #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .halt_i(halt),
    .ring_base_i(ring_base), .busy_o(busy),
    .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_abort_o(tx_abort),
    .tx_nocrc_o(tx_nocrc), .underrun_i(underrun), .retry_i(retry)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_wr) mem[mem_waddr[7:2]] <= mem_wdata;
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem[mem_raddr[7:2]];
  end

  // stream sink ready pattern
  always @(posedge clk) begin
    rdy_cnt  <= rdy_cnt + 1;
    tx_ready <= !bp_mode || (rdy_cnt % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && cap_n < 64) begin
      cap_data[cap_n]  = tx_data;
      cap_last[cap_n]  = tx_last;
      cap_abort[cap_n] = tx_abort;
      cap_nocrc[cap_n] = tx_nocrc;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int w = 0; w < 64; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
  endtask

  task automatic put_desc(input int p, input logic [31:0] bufa, input logic [31:0] ctrl);
    mem[p >> 2]       = bufa;
    mem[(p + 4) >> 2] = ctrl;
  endtask

  task automatic do_reset(input logic [AW-1:0] base);
    rst_n = 1'b0; start = 1'b0; halt = 1'b0; underrun = 1'b0; retry = 1'b0;
    bp_mode = 1'b0; ring_base = base;
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cap_n = 0;
  endtask

  task automatic kick();
    cap_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "busy after run", 32'(busy), 32'd0);
  endtask

  task automatic chk_bytes(input string req, input int idx0, input int a0, input int n);
    for (int i = 0; i < n; i++)
      chk(req, $sformatf("byte %0d", idx0 + i), 32'(cap_data[idx0+i]), 32'(pat(a0 + i)));
  endtask

  task automatic chk_last_map(input string req, input int n, input int lastpos0, input int lastpos1);
    for (int i = 0; i < n; i++)
      chk(req, $sformatf("last %0d", i), 32'(cap_last[i]),
          32'((i == lastpos0) || (i == lastpos1)));
  endtask

  task automatic t_reset();
    do_reset(32'h0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "tx_valid", 32'(tx_valid), 32'd0);
    chk("R1", "mem_rd", 32'(mem_rd), 32'd0);
    chk("R1", "mem_wr", 32'(mem_wr), 32'd0);
  endtask

  task automatic t_single();
    do_reset(32'h0);
    put_desc(32'h00, 32'h40, 32'd5 | F_EOF);
    put_desc(32'h08, 32'h00, F_USED);
    kick();
    wait_idle("R5");
    chk("R2", "count", 32'(cap_n), 32'd5);
    chk_bytes("R2", 0, 32'h40, 5);
    chk_last_map("R3", 5, 4, -1);
    chk("R4", "nocrc", 32'(cap_nocrc[0]), 32'd0);
    chk("R6", "wb ctrl", mem[1], 32'd5 | F_EOF | F_USED);
  endtask

  task automatic t_split_unaligned();
    do_reset(32'h0);
    put_desc(32'h00, 32'h43, 32'd6 | F_NOCRC);
    put_desc(32'h08, 32'h81, 32'd3 | F_EOF);
    put_desc(32'h10, 32'h00, F_USED);
    kick();
    wait_idle("R5");
    chk("R3", "count", 32'(cap_n), 32'd9);
    chk_bytes("R2", 0, 32'h43, 6);
    chk_bytes("R3", 6, 32'h81, 3);
    chk_last_map("R3", 9, 8, -1);
    for (int i = 0; i < 9; i++) chk("R4", "nocrc", 32'(cap_nocrc[i]), 32'd1);
    chk("R6", "first wb", mem[1], 32'd6 | F_NOCRC | F_USED);
    chk("R6", "second untouched", mem[3], 32'd3 | F_EOF);
  endtask

  task automatic t_wrap_resume();
    do_reset(32'h10);
    put_desc(32'h10, 32'h50, 32'd2 | F_EOF);
    put_desc(32'h18, 32'h60, 32'd2 | F_EOF | F_WRAP);
    put_desc(32'h20, 32'h70, 32'd2 | F_EOF);
    kick();
    wait_idle("R7");
    chk("R7", "count", 32'(cap_n), 32'd4);
    chk_bytes("R7", 0, 32'h50, 2);
    chk_bytes("R7", 2, 32'h60, 2);
    chk("R7", "beyond wrap untouched", mem[9], 32'd2 | F_EOF);
    chk("R6", "wrap wb", mem[7], 32'd2 | F_EOF | F_WRAP | F_USED);
    put_desc(32'h10, 32'h90, 32'd3 | F_EOF);
    @(negedge clk);
    kick();
    wait_idle("R5");
    chk("R5", "resume count", 32'(cap_n), 32'd3);
    chk_bytes("R5", 0, 32'h90, 3);
  endtask

  task automatic t_exhausted();
    do_reset(32'h0);
    put_desc(32'h00, 32'h40, 32'd3);
    put_desc(32'h08, 32'h00, F_USED);
    kick();
    wait_idle("R8");
    chk("R8", "count", 32'(cap_n), 32'd4);
    chk_bytes("R8", 0, 32'h40, 3);
    chk("R8", "no last on data", 32'(cap_last[2]), 32'd0);
    chk("R8", "abort beat", 32'(cap_abort[3]), 32'd1);
    chk("R8", "abort last", 32'(cap_last[3]), 32'd1);
    chk("R8", "abort data", 32'(cap_data[3]), 32'd0);
    chk("R8", "wb exh", mem[1], 32'd3 | F_USED | F_EXH);
    chk("R8", "used desc kept", mem[3], F_USED);
  endtask

  task automatic t_errors_bp();
    do_reset(32'h0);
    bp_mode = 1'b1;
    put_desc(32'h00, 32'h40, 32'd20 | F_EOF);
    put_desc(32'h08, 32'hB0, 32'd2 | F_EOF);
    put_desc(32'h10, 32'h00, F_USED);
    kick();
    repeat (10) @(negedge clk);
    underrun = 1'b1;
    @(negedge clk);
    underrun = 1'b0;
    repeat (8) @(negedge clk);
    retry = 1'b1;
    @(negedge clk);
    retry = 1'b0;
    wait_idle("R9");
    chk("R11", "count", 32'(cap_n), 32'd22);
    chk_bytes("R11", 0, 32'h40, 20);
    chk_bytes("R11", 20, 32'hB0, 2);
    chk_last_map("R11", 22, 19, 21);
    chk("R9", "wb errors", mem[1], 32'd20 | F_EOF | F_USED | F_UNDR | F_RTRY);
    chk("R9", "next frame clean", mem[3], 32'd2 | F_EOF | F_USED);
    bp_mode = 1'b0;
  endtask

  task automatic t_halt();
    int n = 0;
    do_reset(32'h0);
    put_desc(32'h00, 32'h40, 32'd8 | F_EOF);
    put_desc(32'h08, 32'h80, 32'd3 | F_EOF);
    put_desc(32'h10, 32'h00, F_USED);
    kick();
    while (cap_n < 2 && n < 500) begin
      @(negedge clk);
      n++;
    end
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    @(negedge clk);
    chk("R10", "busy during frame", 32'(busy), 32'd1);
    wait_idle("R10");
    chk("R10", "count", 32'(cap_n), 32'd8);
    chk_bytes("R10", 0, 32'h40, 8);
    chk("R10", "next desc untouched", mem[3], 32'd3 | F_EOF);
    put_desc(32'h00, 32'hA0, 32'd2 | F_EOF);
    put_desc(32'h08, 32'h80, F_USED);
    @(negedge clk);
    kick();
    wait_idle("R10");
    chk("R10", "rewind count", 32'(cap_n), 32'd2);
    chk_bytes("R10", 0, 32'hA0, 2);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0; cap_n = 0; rdy_cnt = 0;
    bp_mode = 1'b0; tx_ready = 1'b1; rst_n = 1'b0;
    start = 1'b0; halt = 1'b0; underrun = 1'b0; retry = 1'b0; ring_base = '0;
    t_reset();
    t_single();
    t_split_unaligned();
    t_wrap_resume();
    t_exhausted();
    t_errors_bp();
    t_halt();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule